// File: doc/BRIEF.md
# Event-Driven Synchronous Serial Byte Transmitter

This block sends one data byte over a synchronous serial link, least significant bit first, with one data bit per serial clock period. It works from a stream of clock events. In internal mode a free-running timer is compared with a scheduled event time. Each match toggles the serial clock output, and the event time then moves forward by a programmable half period. In external mode every rising and every falling edge of an incoming serial clock counts as an event, after that clock passes through a two-flop synchronizer.

The block counts each event. On alternate events it drives the next data bit onto one bit of a wider output port. A one-hot mask picks that bit, and the other port bits keep whatever they held before. A phase setting chooses whether bits go out on the odd-numbered or the even-numbered events. A full byte takes exactly sixteen events. After the sixteenth event the block drops busy and gives a single-cycle completion interrupt. When idle, the serial clock output rests at a programmable level.

Top module: `sync_tx_engine`

## Requirements
- R1: In internal mode (ext_mode=0), each match between the free-running timer and the scheduled event time toggles sck_out and counts as one event. The next event time is the previous one plus half_period, so consecutive toggles are exactly half_period cycles apart (half_period must be nonzero).
- R2: In external mode (ext_mode=1), both rising and falling edges of sck_in count as events. A change on sck_in takes effect at the third rising clock edge after it: two synchronizer stages, then one edge-detect stage.
- R3: Events are numbered from 1 within a transfer. With odd_phase=0, data bit k (k=0 first, LSB first) is driven at event 2k+2. With odd_phase=1 it is driven at event 2k+1. No other event drives the port.
- R4: A transfer ends after exactly 16 events. In the cycle after the clock edge of the 16th event, busy is low and done_irq is high for exactly one cycle. done_irq is low at every other time.
- R5: A drive event writes the data bit to the port_out bits set in the latched one-hot port_mask. All other port_out bits keep their previous values, including bits written by earlier transfers.
- R6: A start pulse while idle loads data_in and clears the event count, and busy is high on the next cycle. ext_mode, odd_phase, port_mask and half_period are latched at that start pulse, so later changes to them have no effect on the running transfer. A start pulse while busy is ignored.
- R7: While idle, sck_out follows idle_level one cycle later. In external mode sck_out stays at idle_level for the whole transfer. After an internal-mode transfer sck_out ends at idle_level.
- R8: During reset, busy, done_irq, sck_out and all of port_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse, accepted only when idle) |
| data_in | input | DATA_W | Byte to send, loaded on start |
| ext_mode | input | 1 | 0: internal timer clock, 1: external serial clock |
| odd_phase | input | 1 | 0: drive bits on even events, 1: on odd events |
| idle_level | input | 1 | Resting level of sck_out while idle |
| half_period | input | TMR_W | Timer cycles between internal clock toggles |
| port_mask | input | PORT_W | One-hot choice of the port bit that carries data |
| sck_in | input | 1 | External serial clock (asynchronous) |
| sck_out | output | 1 | Generated serial clock |
| port_out | output | PORT_W | Output port; one masked bit carries data |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check on every cycle that done_irq is a lone pulse that only follows the final event of a busy transfer, and that port_out never changes outside the latched mask or by more than one bit. They also check that every internal timer event flips the serial clock, that the idle clock tracks idle_level, and that a start pulse during a transfer changes neither busy nor the event count. Only the bench scenarios can show the content of a transfer: the LSB-first bit order under each phase setting, the exact half-period spacing of generated toggles, the three-edge latency of an external edge, and the retention of port bits written by earlier transfers with other masks.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic { CLK_INTERNAL = 1'b0, CLK_EXTERNAL = 1'b1 } clk_src_e;
  typedef enum logic { PH_EVEN = 1'b0, PH_ODD = 1'b1 } phase_e;

  // Events are numbered from 1, so event number = count + 1.
  // That number is even exactly when the count's low bit is 1.
  function automatic logic drive_on_event(input logic cnt_lsb, input phase_e ph);
    return (ph == PH_EVEN) ? cnt_lsb : ~cnt_lsb;
  endfunction
endpackage

// File: rtl/sst_event_gen.sv
module sst_event_gen #(
  parameter int TMR_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             busy,
  input  logic             ext_sel,
  input  logic [TMR_W-1:0] half_period,
  input  logic             idle_level,
  input  logic             sck_in,
  output logic             int_ev,
  output logic             ext_ev,
  output logic             sck_out
);
  import sst_pkg::*;

  localparam int PIPE_W = SYNC_N + 1;

  logic [TMR_W-1:0]  tmr_q;
  logic [TMR_W-1:0]  evt_time_q;
  logic [TMR_W-1:0]  hp_q;
  clk_src_e          src_q;
  logic [PIPE_W-1:0] pipe_q;
  logic              sck_q;
  logic              sync_edge;

  function automatic logic [TMR_W-1:0] next_time(input logic [TMR_W-1:0] base,
                                                 input logic [TMR_W-1:0] step);
    return base + step;
  endfunction

  // Timer compare and rescheduling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q      <= '0;
      evt_time_q <= '0;
      hp_q       <= '0;
      src_q      <= CLK_INTERNAL;
    end else begin
      tmr_q <= tmr_q + 1'b1;
      if (load) begin
        src_q      <= clk_src_e'(ext_sel);
        hp_q       <= half_period;
        evt_time_q <= next_time(tmr_q, half_period);
      end else if (int_ev) begin
        evt_time_q <= next_time(evt_time_q, hp_q);
      end
    end
  end

  // Synchronizer stages plus one edge-detect stage
  generate
    for (genvar g = 0; g < PIPE_W; g++) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= 1'b0;
        else if (g == 0) pipe_q[g] <= sck_in;
        else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_edge = pipe_q[PIPE_W-1] ^ pipe_q[PIPE_W-2];

  assign int_ev = busy && (src_q == CLK_INTERNAL) && (tmr_q == evt_time_q);
  assign ext_ev = busy && (src_q == CLK_EXTERNAL) && sync_edge;

  // Serial clock output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sck_q <= 1'b0;
    else if (!busy)  sck_q <= idle_level;
    else if (int_ev) sck_q <= ~sck_q;
  end

  assign sck_out = sck_q;
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DATA_W = 8,
  parameter int PORT_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic              odd_phase,
  input  logic [PORT_W-1:0] port_mask,
  input  logic              ev,
  output logic              load,
  output logic              busy,
  output logic              drive,
  output logic              done_irq,
  output logic [CNT_W-1:0]  cnt,
  output logic [PORT_W-1:0] mask_q,
  output logic [PORT_W-1:0] port_out
);
  import sst_pkg::*;

  localparam int EVENTS = 2 * DATA_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EVENTS - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PORT_W-1:0] port_q;
  phase_e            phase_q;
  logic              busy_q;
  logic              done_q;

  function automatic logic [PORT_W-1:0] merge_bit(input logic [PORT_W-1:0] cur,
                                                  input logic [PORT_W-1:0] sel,
                                                  input logic              b);
    return (cur & ~sel) | (sel & {PORT_W{b}});
  endfunction

  assign load  = start && !busy_q;
  assign drive = busy_q && ev && drive_on_event(cnt_q[0], phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      port_q  <= '0;
      mask_q  <= '0;
      phase_q <= PH_EVEN;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        shreg_q <= data_in;
        cnt_q   <= '0;
        mask_q  <= port_mask;
        phase_q <= phase_e'(odd_phase);
        busy_q  <= 1'b1;
      end else if (busy_q && ev) begin
        cnt_q <= cnt_q + 1'b1;
        if (drive) begin
          port_q  <= merge_bit(port_q, mask_q, shreg_q[0]);
          shreg_q <= shreg_q >> 1;
        end
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done_irq = done_q;
  assign cnt      = cnt_q;
  assign port_out = port_q;
endmodule

// File: rtl/sync_tx_engine.sv
module sync_tx_engine #(
  parameter int DATA_W = 8,
  parameter int PORT_W = 8,
  parameter int TMR_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ext_mode,
  input  logic              odd_phase,
  input  logic              idle_level,
  input  logic [TMR_W-1:0]  half_period,
  input  logic [PORT_W-1:0] port_mask,
  input  logic              sck_in,
  output logic              sck_out,
  output logic [PORT_W-1:0] port_out,
  output logic              busy,
  output logic              done_irq
);
  localparam int EVENTS = 2 * DATA_W;
  localparam int CNT_W  = $clog2(EVENTS);

  logic             load;
  logic             int_ev;
  logic             ext_ev;
  logic             ev;
  logic             drive;
  logic [CNT_W-1:0] cnt;
  logic [PORT_W-1:0] mask_q;

  assign ev = int_ev | ext_ev;

  sst_event_gen #(.TMR_W(TMR_W), .SYNC_N(SYNC_N)) u_evgen (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy),
    .ext_sel(ext_mode), .half_period(half_period), .idle_level(idle_level),
    .sck_in(sck_in), .int_ev(int_ev), .ext_ev(ext_ev), .sck_out(sck_out)
  );

  sst_shifter #(.DATA_W(DATA_W), .PORT_W(PORT_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .odd_phase(odd_phase), .port_mask(port_mask), .ev(ev),
    .load(load), .busy(busy), .drive(drive), .done_irq(done_irq),
    .cnt(cnt), .mask_q(mask_q), .port_out(port_out)
  );
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              idle_level,
  input logic              busy,
  input logic              done_irq,
  input logic              sck_out,
  input logic [PORT_W-1:0] port_out,
  input logic [PORT_W-1:0] mask_q,
  input logic              ev,
  input logic              int_ev,
  input logic              drive,
  input logic [CNT_W-1:0]  cnt
);
  // R4: completion is a lone pulse
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R4: completion only follows an event of a busy transfer, with busy low
  assert_done_after_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && $past(busy) && $past(ev)));
  // R5: bits outside the latched mask never move
  assert_unmasked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_out ^ $past(port_out)) & ~$past(mask_q)) == '0);
  // R5: at most one port bit changes per cycle
  assert_one_bit_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_out ^ $past(port_out)) <= 1);
  // R3: port only changes after a drive event, which is itself an event
  assert_port_on_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_out != $past(port_out)) |-> $past(drive));
  assert_drive_is_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (ev && busy));
  // R1: every internal timer event flips the serial clock
  assert_int_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int_ev |=> (sck_out != $past(sck_out)));
  // R7: idle clock level tracks idle_level one cycle later
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(busy)) |-> (sck_out == $past(idle_level)));
  // R6: start during a transfer changes neither busy nor the count
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ev) |=> (busy && $stable(cnt)));
endmodule

bind sync_tx_engine sst_checker #(.PORT_W(PORT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle_level(idle_level),
  .busy(busy), .done_irq(done_irq), .sck_out(sck_out), .port_out(port_out),
  .mask_q(mask_q), .ev(ev), .int_ev(int_ev), .drive(drive), .cnt(cnt)
);

// File: tb/tb_sync_tx_engine.sv
module tb_sync_tx_engine;
  localparam int DW = 8;
  localparam int PW = 8;
  localparam int TW = 16;
  localparam int NV = 6;

  // {ext, odd, idle, mask[7:0], data[7:0], half_period[15:0]}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'h01, 8'hA5, 16'd3},
    {1'b0, 1'b1, 1'b1, 8'h80, 8'h3C, 16'd5},
    {1'b1, 1'b0, 1'b0, 8'h10, 8'h96, 16'd7},
    {1'b1, 1'b1, 1'b1, 8'h04, 8'h0F, 16'd7},
    {1'b0, 1'b1, 1'b0, 8'h02, 8'h01, 16'd1},
    {1'b0, 1'b0, 1'b1, 8'h40, 8'h80, 16'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic ext_mode = 1'b0;
  logic odd_phase = 1'b0;
  logic idle_level = 1'b0;
  logic [TW-1:0] half_period = 16'd1;
  logic [PW-1:0] port_mask = 8'h01;
  logic sck_in = 1'b0;
  logic sck_out;
  logic [PW-1:0] port_out;
  logic busy;
  logic done_irq;

  int total = 0;
  int bad = 0;
  logic [PW-1:0] exp_port = '0;

  always #2.5 clk = ~clk;

  sync_tx_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .ext_mode(ext_mode), .odd_phase(odd_phase), .idle_level(idle_level),
    .half_period(half_period), .port_mask(port_mask), .sck_in(sck_in),
    .sck_out(sck_out), .port_out(port_out), .busy(busy), .done_irq(done_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench model of one event: R3 bit order and phase, R5 masked merge, R4 end
  task automatic on_event(input int n, input bit odd, input logic [7:0] mask,
                          input logic [7:0] data, inout int k);
    bit drv;
    drv = odd ? (n % 2 == 1) : (n % 2 == 0);
    if (drv) begin
      exp_port = (exp_port & ~mask) | (data[k] ? mask : 8'h00);
      k++;
    end
    chk(port_out === exp_port, "R3 R5 port after event", port_out, exp_port);
    if (n == 16) begin
      chk(done_irq === 1'b1, "R4 done after 16th event", done_irq, 1);
      chk(busy === 1'b0, "R4 busy low after 16th event", busy, 0);
    end else begin
      chk(done_irq === 1'b0, "R4 no early done", done_irq, 0);
      chk(busy === 1'b1, "R4 busy during transfer", busy, 1);
    end
  endtask

  task automatic run_xfer(input bit ext, input bit odd, input bit idl,
                          input logic [7:0] mask, input logic [7:0] data,
                          input logic [15:0] hp, input int glitch);
    int n = 0;
    int k = 0;
    int cyc = 0;
    int last = 0;
    bit gdone = 0;
    logic prev;
    @(negedge clk);
    ext_mode = ext; odd_phase = odd; idle_level = idl;
    port_mask = mask; half_period = hp; data_in = data;
    @(negedge clk);
    @(negedge clk);
    chk(sck_out === idl, "R7 idle level before start", sck_out, idl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after start", busy, 1);
    // R6: configuration changes after start must not matter
    port_mask = 8'h00; odd_phase = ~odd; ext_mode = ~ext;
    half_period = hp + 16'd3; data_in = ~data;
    prev = sck_out;
    if (!ext) begin
      while (n < 16 && cyc < 40 * hp + 100) begin
        @(negedge clk);
        cyc++;
        start = 1'b0;
        if (sck_out !== prev) begin
          n++;
          prev = sck_out;
          if (n > 1) chk(cyc - last == int'(hp), "R1 toggle spacing", cyc - last, hp);
          last = cyc;
          on_event(n, odd, mask, data, k);
        end else begin
          chk(done_irq === 1'b0, "R4 done without event", done_irq, 0);
        end
        if (glitch != 0 && n == glitch && !gdone) begin
          start = 1'b1;
          gdone = 1;
        end
      end
    end else begin
      for (int i = 1; i <= 16; i++) begin
        sck_in = ~sck_in;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(port_out === exp_port, "R2 no effect before third edge", port_out, exp_port);
        @(negedge clk);
        n++;
        chk(sck_out === idl, "R7 sck idle in external mode", sck_out, idl);
        on_event(n, odd, mask, data, k);
      end
    end
    start = 1'b0;
    chk(n == 16, "R4 event count", n, 16);
    @(negedge clk);
    chk(done_irq === 1'b0, "R4 single pulse", done_irq, 0);
    chk(sck_out === idl, "R7 sck back at idle level", sck_out, idl);
    repeat (3 * int'(hp) + 4) @(negedge clk);
    chk(busy === 1'b0 && sck_out === idl, "R7 stays idle", {busy, sck_out}, {1'b0, idl});
    chk(port_out === exp_port, "R5 port holds after transfer", port_out, exp_port);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: reset state
    idle_level = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R8 busy in reset", busy, 0);
    chk(done_irq === 1'b0, "R8 done in reset", done_irq, 0);
    chk(port_out === 8'h00, "R8 port in reset", port_out, 0);
    chk(sck_out === 1'b0, "R8 sck in reset", sck_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(sck_out === 1'b1, "R7 idle level after reset", sck_out, 1);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      run_xfer(VEC[v][34], VEC[v][33], VEC[v][32], VEC[v][31:24],
               VEC[v][23:16], VEC[v][15:0], 0);
    end

    // R6: start pulse in the middle of a transfer is ignored
    run_xfer(1'b0, 1'b0, 1'b0, 8'h08, 8'h5A, 16'd4, 5);
    run_xfer(1'b0, 1'b1, 1'b1, 8'h20, 8'hC3, 16'd2, 9);
    // R5: earlier bits kept while a new bit position is written
    run_xfer(1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 16'd1, 0);

    // R7: idle level follows input with one cycle lag
    @(negedge clk);
    idle_level = 1'b0;
    @(negedge clk);
    chk(sck_out === 1'b0, "R7 idle follows low", sck_out, 0);
    idle_level = 1'b1;
    @(negedge clk);
    chk(sck_out === 1'b1, "R7 idle follows high", sck_out, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule